// File: doc/BRIEF.md
# Transaction Commit Controller

This block decides when a batch of staged register writes becomes visible all at once. Software opens a batch by reading the control register. The read advances a rolling transaction number, returns the new number, and throws away anything staged before it. Software then stages its data writes into shadow storage. That storage sits outside this block and only reports each staged write here. To close the batch, software writes the number it was given back to the control register. The staged writes are applied in a single cycle only if that number is still the current one. Any other value throws them away.

A second, read-only register holds the number of the most recent batch that was applied. After closing a batch, software reads it. If it equals the number received at the start, the batch went through. Otherwise another context opened its own batch in between, and the first context retries. No lock and no disabled interrupts are needed. The shadow storage is told what to do through two one-cycle strobes, apply and discard.

Top module: `tx_commit_ctrl`

## Requirements
- R1: After reset the transaction number and the last-applied register are both 0, nothing is marked staged, and the apply strobe, discard strobe and read-valid outputs are all low.
- R2: A read with `regSel`=0 (control register) increments the transaction number by one. In the next cycle `regRdValid` is high and `regRdData` holds the incremented value.
- R3: A control-register read raises `abortStb` for exactly one cycle after the access and clears the staged indication.
- R4: A control-register write whose data equals the current transaction number raises `commitStb` for one cycle after the access, keeps `abortStb` low, clears the staged indication, and leaves the transaction number unchanged.
- R5: On such a matching write the current number is copied into the last-applied register. A read with `regSel`=1 returns that register one cycle later with `regRdValid` high.
- R6: A control-register write whose data differs from the current number raises `abortStb` for one cycle. It leaves `commitStb` low, the last-applied register unchanged and the transaction number unchanged.
- R7: The transaction number counts modulo 2^ID_W: a begin at the all-ones value yields 0.
- R8: Writes with `regSel`=1 have no effect on either register or on the strobes.
- R9: A `stageWr` pulse with no control access in the same cycle sets `stagePending`, which stays high until an apply or discard clears it.
- R10: `commitStb` and `abortStb` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 1 | 0 selects the control register, 1 the last-applied register |
| regRd | input | 1 | Read request for the selected register |
| regWr | input | 1 | Write request for the selected register |
| regWrData | input | ID_W | Write data |
| stageWr | input | 1 | Pulse from shadow storage: one data write was staged |
| regRdData | output | ID_W | Read data, valid the cycle after a read |
| regRdValid | output | 1 | High for one cycle when regRdData carries a response |
| commitStb | output | 1 | One-cycle strobe: apply all staged writes |
| abortStb | output | 1 | One-cycle strobe: discard all staged writes |
| stagePending | output | 1 | High while at least one staged write awaits apply or discard |

## Verification
The assertions assume that a read and a write are never requested in the same cycle, because the decode gives neither one priority. An embedded check flags any violation. The stimulus issues exactly one register operation or one staging pulse per cycle, so a staging pulse never coincides with a control access. Under that rule, each strobe and register update can be traced to one access. The nested-batch sequence then models a preempting context entirely through ordinary single accesses.

// File: rtl/tx_commit_pkg.sv
package tx_commit_pkg;

  // Register select encoding on regSel
  localparam logic SEL_CTRL = 1'b0;
  localparam logic SEL_DONE = 1'b1;

  // Strobes passed from the control decode to the datapath
  typedef struct packed {
    logic beginTx;   // control read: roll back, then open a new batch
    logic commitTx;  // control write with matching number
    logic abortTx;   // control write with stale number
    logic readDone;  // read of the last-applied register
    logic markStage; // shadow storage staged one write
  } txCmd_t;

endpackage

// File: rtl/tx_commit_decode.sv
module tx_commit_decode
  import tx_commit_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   regSel,
  input  logic   regRd,
  input  logic   regWr,
  input  logic   stageWr,
  input  logic   idMatch,
  output txCmd_t cmd,
  output logic   commitStb,
  output logic   abortStb
);

  logic isCtrl;
  logic ctrlAccess;

  always_comb begin
    isCtrl         = (regSel == SEL_CTRL);
    cmd            = '0;
    cmd.beginTx    = regRd && isCtrl;
    cmd.readDone   = regRd && !isCtrl;
    cmd.commitTx   = regWr && isCtrl && idMatch;
    cmd.abortTx    = regWr && isCtrl && !idMatch;
    ctrlAccess     = cmd.beginTx || cmd.commitTx || cmd.abortTx;
    cmd.markStage  = stageWr && !ctrlAccess;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      commitStb <= 1'b0;
      abortStb  <= 1'b0;
    end else begin
      commitStb <= cmd.commitTx;
      abortStb  <= cmd.abortTx || cmd.beginTx;
    end
  end

  // R10: apply and discard are exclusive
  assert_strobe_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(commitStb && abortStb));

  // R4: a matching control write yields an apply strobe next cycle
  assert_commit_follows_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && isCtrl && idMatch && !regRd) |=> commitStb);

  // R6: a stale control write yields a discard strobe next cycle
  assert_abort_follows_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && isCtrl && !idMatch && !regRd) |=> (abortStb && !commitStb));

  // Input rule: read and write never requested together
  assert_no_rd_wr_overlap_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(regRd && regWr));

endmodule

// File: rtl/tx_commit_datapath.sv
module tx_commit_datapath
  import tx_commit_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  txCmd_t          cmd,
  input  logic [ID_W-1:0] regWrData,
  output logic            idMatch,
  output logic [ID_W-1:0] regRdData,
  output logic            regRdValid,
  output logic            stagePending
);

  localparam logic [ID_W-1:0] ID_ONE = ID_W'(1);

  logic [ID_W-1:0] txId;
  logic [ID_W-1:0] doneId;
  logic [ID_W-1:0] nextId;

  always_comb begin
    nextId  = txId + ID_ONE; // wraps modulo 2^ID_W
    idMatch = (regWrData == txId);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txId <= '0;
    end else if (cmd.beginTx) begin
      txId <= nextId;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneId <= '0;
    end else if (cmd.commitTx) begin
      doneId <= txId;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stagePending <= 1'b0;
    end else if (cmd.beginTx || cmd.commitTx || cmd.abortTx) begin
      stagePending <= 1'b0;
    end else if (cmd.markStage) begin
      stagePending <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRdData  <= '0;
      regRdValid <= 1'b0;
    end else begin
      regRdValid <= cmd.beginTx || cmd.readDone;
      if (cmd.beginTx) begin
        regRdData <= nextId;
      end else if (cmd.readDone) begin
        regRdData <= doneId;
      end
    end
  end

  // R2: a begin advances the number by one
  assert_begin_advances_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmd.beginTx |=> (txId == $past(txId) + ID_ONE));

  // R5: an apply copies the number into the last-applied register
  assert_commit_latches_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmd.commitTx |=> (doneId == $past(txId)));

  // R6: without an apply the last-applied register holds
  assert_done_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.commitTx |=> $stable(doneId));

  // R3: a begin clears the staged indication
  assert_begin_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.beginTx |=> !stagePending);

  // R9: a lone staging pulse sets the staged indication
  assert_stage_sets_R9: assert property (@(posedge clk) disable iff (!rstN)
    cmd.markStage |=> stagePending);

endmodule

// File: rtl/tx_commit_ctrl.sv
module tx_commit_ctrl
  import tx_commit_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            regSel,
  input  logic            regRd,
  input  logic            regWr,
  input  logic [ID_W-1:0] regWrData,
  input  logic            stageWr,
  output logic [ID_W-1:0] regRdData,
  output logic            regRdValid,
  output logic            commitStb,
  output logic            abortStb,
  output logic            stagePending
);

  txCmd_t cmd;
  logic   idMatch;

  tx_commit_decode i_decode (
    .clk       (clk),
    .rstN      (rstN),
    .regSel    (regSel),
    .regRd     (regRd),
    .regWr     (regWr),
    .stageWr   (stageWr),
    .idMatch   (idMatch),
    .cmd       (cmd),
    .commitStb (commitStb),
    .abortStb  (abortStb)
  );

  tx_commit_datapath #(.ID_W(ID_W)) i_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .cmd          (cmd),
    .regWrData    (regWrData),
    .idMatch      (idMatch),
    .regRdData    (regRdData),
    .regRdValid   (regRdValid),
    .stagePending (stagePending)
  );

endmodule

// File: tb/test_tx_commit_ctrl.sv
module test_tx_commit_ctrl;

  localparam int W = 8;
  // Operation codes used by the bench
  localparam logic [1:0] OP_STAGE = 2'd0;
  localparam logic [1:0] OP_CRD   = 2'd1;
  localparam logic [1:0] OP_CWR   = 2'd2;
  localparam logic [1:0] OP_DRD   = 2'd3;

  // Vector: {op, data, expRd, expCommit, expAbort, expPend}
  localparam int NV = 12;
  localparam logic [20:0] VEC [NV] = '{
    {OP_STAGE, 8'd0, 8'd0, 1'b0, 1'b0, 1'b1},
    {OP_CRD,   8'd0, 8'd1, 1'b0, 1'b1, 1'b0},
    {OP_STAGE, 8'd0, 8'd0, 1'b0, 1'b0, 1'b1},
    {OP_CWR,   8'd1, 8'd0, 1'b1, 1'b0, 1'b0},
    {OP_DRD,   8'd0, 8'd1, 1'b0, 1'b0, 1'b0},
    {OP_CRD,   8'd0, 8'd2, 1'b0, 1'b1, 1'b0},
    {OP_STAGE, 8'd0, 8'd0, 1'b0, 1'b0, 1'b1},
    {OP_CWR,   8'd5, 8'd0, 1'b0, 1'b1, 1'b0},
    {OP_DRD,   8'd0, 8'd1, 1'b0, 1'b0, 1'b0},
    {OP_CRD,   8'd0, 8'd3, 1'b0, 1'b1, 1'b0},
    {OP_CWR,   8'd3, 8'd0, 1'b1, 1'b0, 1'b0},
    {OP_DRD,   8'd0, 8'd3, 1'b0, 1'b0, 1'b0}
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         regSel = 1'b0;
  logic         regRd = 1'b0;
  logic         regWr = 1'b0;
  logic [W-1:0] regWrData = '0;
  logic         stageWr = 1'b0;
  logic [W-1:0] regRdData;
  logic         regRdValid;
  logic         commitStb;
  logic         abortStb;
  logic         stagePending;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  tx_commit_ctrl #(.ID_W(W)) i_tx_commit_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .regSel       (regSel),
    .regRd        (regRd),
    .regWr        (regWr),
    .regWrData    (regWrData),
    .stageWr      (stageWr),
    .regRdData    (regRdData),
    .regRdValid   (regRdValid),
    .commitStb    (commitStb),
    .abortStb     (abortStb),
    .stagePending (stagePending)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one operation for one cycle; return just after the capturing edge
  task automatic doOp(input logic [1:0] op, input logic [W-1:0] data);
    @(negedge clk);
    regRd = 1'b0; regWr = 1'b0; stageWr = 1'b0; regSel = 1'b0;
    regWrData = data;
    case (op)
      OP_STAGE: stageWr = 1'b1;
      OP_CRD:   regRd = 1'b1;
      OP_CWR:   regWr = 1'b1;
      default:  begin regRd = 1'b1; regSel = 1'b1; end
    endcase
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    regRd = 1'b0; regWr = 1'b0; stageWr = 1'b0; regSel = 1'b0;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] idA;
    logic [W-1:0] idB;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 commitStb", int'(commitStb), 0);
    check("R1 abortStb", int'(abortStb), 0);
    check("R1 pending", int'(stagePending), 0);
    check("R1 rdValid", int'(regRdValid), 0);
    @(negedge clk);
    rstN = 1'b1;
    doOp(OP_DRD, '0);
    check("R1 done after reset", int'(regRdData), 0);

    // Table walk: R2 R3 R4 R5 R6 R9 R10
    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      op = VEC[i][20:19];
      doOp(op, VEC[i][18:11]);
      check("R4 commit", int'(commitStb), int'(VEC[i][2]));
      check("R3 R6 abort", int'(abortStb), int'(VEC[i][1]));
      check("R9 pending", int'(stagePending), int'(VEC[i][0]));
      check("R10 exclusive", int'(commitStb && abortStb), 0);
      if (op == OP_CRD || op == OP_DRD) begin
        check("R2 R5 rdValid", int'(regRdValid), 1);
        check("R2 R5 rdData", int'(regRdData), int'(VEC[i][10:3]));
      end
    end
    idle();
    check("R4 one-cycle strobe", int'(commitStb), 0);

    // R9: pending holds across idle cycles
    doOp(OP_STAGE, '0);
    idle(); idle();
    check("R9 pending held", int'(stagePending), 1);

    // R7: advance to 255, apply it, then wrap to 0 (number is 3 here)
    for (int k = 0; k < 252; k++) doOp(OP_CRD, '0);
    check("R7 reach max", int'(regRdData), 255);
    check("R3 pending cleared by begin", int'(stagePending), 0);
    doOp(OP_CWR, 8'd255);
    check("R4 commit at max", int'(commitStb), 1);
    doOp(OP_CRD, '0);
    check("R7 wrap", int'(regRdData), 0);
    doOp(OP_DRD, '0);
    check("R5 done max", int'(regRdData), 255);

    // R8: done-register write ignored
    @(negedge clk);
    regRd = 1'b0; regSel = 1'b1; regWr = 1'b1; regWrData = 8'h55;
    @(posedge clk); #1;
    check("R8 no commit", int'(commitStb), 0);
    check("R8 no abort", int'(abortStb), 0);
    doOp(OP_DRD, '0);
    check("R8 done unchanged", int'(regRdData), 255);
    doOp(OP_CWR, 8'd0);
    check("R8 number unchanged", int'(commitStb), 1);

    // Preempted batch: A opens, B opens and applies, A's close is stale
    doOp(OP_CRD, '0); idA = regRdData;
    doOp(OP_STAGE, '0);
    doOp(OP_CRD, '0); idB = regRdData;
    check("R3 nested begin discards", int'(abortStb), 1);
    doOp(OP_CWR, idB);
    check("R4 inner apply", int'(commitStb), 1);
    doOp(OP_CWR, idA);
    check("R6 outer stale", int'(abortStb), 1);
    check("R6 outer no commit", int'(commitStb), 0);
    doOp(OP_DRD, '0);
    check("R5 done is inner", int'(regRdData), int'(idB));
    check("R6 outer detects loss", int'(regRdData != idA), 1);
    idle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule